// File: doc/BRIEF.md
# MESI snooping cache controller

This block is the coherence controller of one core's private cache. The cache is small, direct-mapped and write-back, and each line holds several words. Every line carries one of four coherence codes: Modified, Exclusive, Shared or Invalid. Through these codes the controller keeps its copy consistent with the caches of the other cores, using an invalidate policy on a shared broadcast bus.

The processor side raises a request and holds it until `cpu_done`. A request that can be served locally finishes in the same cycle. Any other request raises `bm_req` with a command and a line address. The transaction completes in the single cycle in which the external arbiter asserts `bm_gnt`. In that cycle the bus returns the line on `bm_rdata`, and the wired-OR holder line on `bm_shared`.

The snoop side sees each transaction issued by another core for one cycle on `sn_valid`. It answers in that same cycle. It reports that it holds the line, drives the line data so that the memory access can be dropped, and flags when that data must also be written to memory. It then updates its own code at the clock edge.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After synchronous reset every line is Invalid, `cpu_stall` and `bm_req` are low, and a snooped read produces no response.
- R2: A read whose tag matches a line in M, E or S asserts `cpu_done` in the request cycle with the addressed word on `cpu_rdata`, issues no bus command, and leaves the code unchanged. The word offset is address bit 0, and word 0 sits in the low bits of a line.
- R3: A read miss issues a bus read (`bm_cmd`=1) on the line address, which is the word address shifted right by one. When `bm_shared` is low in the grant cycle, the line is installed as Exclusive and the word is returned in that cycle.
- R4: A read miss granted with `bm_shared` high installs the line as Shared with the data taken from the bus.
- R5: A write that hits a line in E or M updates the word locally with no bus command, and leaves the line in M.
- R6: A snooped read (`sn_cmd`=1) that matches a valid line asserts `sn_hit` and `sn_supply` and drives the whole line on `sn_data`. It asserts `sn_wb` only when the line is in M. After the read the line is Shared.
- R7: A write that hits a line in S issues an invalidate (`bm_cmd`=3), and on grant merges the word and moves the line to M.
- R8: A snooped read-for-ownership (`sn_cmd`=2) that matches a valid line supplies the line, asserts `sn_wb` only if the line was in M, and leaves it Invalid.
- R9: A snooped invalidate (`sn_cmd`=3) that matches drives no data and no write-back, and leaves the line Invalid.
- R10: A write miss issues a read-for-ownership (`bm_cmd`=2). On grant it merges the written word into the returned line and installs it as M.
- R11: A miss that would displace an M line of another tag first issues a write-back (`bm_cmd`=4) carrying the old line and its line address, and then issues the fill. Displacing an E or S line issues only the fill.
- R12: In a cycle with `sn_valid` high, no processor request completes. A held request finishes in a later cycle.
- R13: `bm_req` is raised only while a processor request is held, and `cpu_stall` is high while a request is waiting for grant.
- R14: A snoop whose tag differs from the stored tag produces no response and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Word address |
| cpu_wdata | input | 16 | Write word |
| cpu_rdata | output | 16 | Read word, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes at the next edge |
| cpu_stall | output | 1 | Request held but not completing |
| bm_req | output | 1 | Bus request |
| bm_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bm_cmd | output | 3 | 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bm_laddr | output | 9 | Line address of the transaction |
| bm_wdata | output | 32 | Line written back |
| bm_rdata | input | 32 | Line returned by the bus in the grant cycle |
| bm_shared | input | 1 | Wired-OR holder line, valid in the grant cycle |
| sn_valid | input | 1 | Another core's transaction is on the bus |
| sn_cmd | input | 3 | Snooped command, same codes as `bm_cmd` |
| sn_laddr | input | 9 | Snooped line address |
| sn_hit | output | 1 | This cache holds the snooped line (read kinds) |
| sn_supply | output | 1 | This cache drives the line; memory access is dropped |
| sn_wb | output | 1 | Supplied line is dirty and goes to memory too |
| sn_data | output | 32 | Supplied line |

## Verification
The bench walks one line through every code transition. A design that upgrades from Exclusive through the bus, or that installs Exclusive despite a holder, shows up as an extra or a missing invalidate on a later write. Snoops check the response to a Modified line against Exclusive and Shared copies, so a controller that forgets the write-back or stays valid after a read-for-ownership gives a wrong `sn_wb` or a wrong refill. Conflict misses check that a dirty victim is written back with its own line address before the fill, and that a clean victim is dropped silently. A hit presented together with a snoop must not complete in that cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int OFS_W   = 1;
    localparam int IDX_W   = 2;
    localparam int WORDS   = 1 << OFS_W;
    localparam int LINES   = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
    localparam int LADDR_W = ADDR_W - OFS_W;
    localparam int LINE_W  = DATA_W * WORDS;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } coh_t;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_INV  = 3'd3,
        BC_WB   = 3'd4
    } bcmd_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        coh_t              st;
        logic [LINE_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                    input logic [OFS_W-1:0] o);
        return l[int'(o)*DATA_W +: DATA_W];
    endfunction

    function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] l,
                                                     input logic [OFS_W-1:0] o,
                                                     input logic [DATA_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = l;
        r[int'(o)*DATA_W +: DATA_W] = w;
        return r;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output line_t            line_a,
    output line_t            line_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);

    line_t lines [LINES];

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[gi] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(gi)) begin
                lines[gi] <= wr_line;
            end
        end
    end

    assign line_a = lines[rd_idx_a];
    assign line_b = lines[rd_idx_b];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic               sn_valid,
    input  logic [2:0]         sn_cmd,
    input  logic [LADDR_W-1:0] sn_laddr,
    input  line_t              cur,
    output logic               sn_hit,
    output logic               sn_supply,
    output logic               sn_wb,
    output logic [LINE_W-1:0]  sn_data,
    output logic               upd_en,
    output line_t              upd_line
);

    logic match;

    assign match = sn_valid && (cur.st != ST_I)
                   && (cur.tag == sn_laddr[LADDR_W-1 -: TAG_W]);

    always_comb begin
        sn_hit    = 1'b0;
        sn_supply = 1'b0;
        sn_wb     = 1'b0;
        sn_data   = '0;
        upd_en    = 1'b0;
        upd_line  = cur;
        if (match) begin
            case (bcmd_t'(sn_cmd))
                BC_RD: begin
                    sn_hit      = 1'b1;
                    sn_supply   = 1'b1;
                    sn_wb       = (cur.st == ST_M);
                    sn_data     = cur.data;
                    upd_en      = 1'b1;
                    upd_line.st = ST_S;
                end
                BC_RDX: begin
                    sn_hit      = 1'b1;
                    sn_supply   = 1'b1;
                    sn_wb       = (cur.st == ST_M);
                    sn_data     = cur.data;
                    upd_en      = 1'b1;
                    upd_line.st = ST_I;
                end
                BC_INV: begin
                    upd_en      = 1'b1;
                    upd_line.st = ST_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
    import mesi_pkg::*;
(
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  line_t              cur,
    input  logic               snoop_busy,
    input  logic               bm_gnt,
    input  logic [LINE_W-1:0]  bm_rdata,
    input  logic               bm_shared,
    output logic               cpu_done,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               bm_req,
    output bcmd_t              bm_cmd,
    output logic [LADDR_W-1:0] bm_laddr,
    output logic [LINE_W-1:0]  bm_wdata,
    output logic               upd_en,
    output line_t              upd_line
);

    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic [OFS_W-1:0] ofs;
    logic             tag_hit;
    logic             local_ok;
    logic             fin;

    assign tag      = tag_of(cpu_addr);
    assign idx      = idx_of(cpu_addr);
    assign ofs      = ofs_of(cpu_addr);
    assign tag_hit  = (cur.st != ST_I) && (cur.tag == tag);
    assign local_ok = tag_hit && (!cpu_we || cur.st == ST_M || cur.st == ST_E);
    assign fin      = bm_req && bm_gnt;

    always_comb begin
        bm_cmd   = BC_NONE;
        bm_laddr = {tag, idx};
        bm_wdata = '0;
        if (cpu_req && !local_ok) begin
            if (cur.st == ST_M && !tag_hit) begin
                bm_cmd   = BC_WB;
                bm_laddr = {cur.tag, idx};
                bm_wdata = cur.data;
            end else if (cpu_we && tag_hit) begin
                bm_cmd = BC_INV;
            end else if (cpu_we) begin
                bm_cmd = BC_RDX;
            end else begin
                bm_cmd = BC_RD;
            end
        end
    end

    assign bm_req = (bm_cmd != BC_NONE);

    always_comb begin
        cpu_done  = 1'b0;
        cpu_rdata = pick_word(cur.data, ofs);
        upd_en    = 1'b0;
        upd_line  = cur;
        if (cpu_req && local_ok && !snoop_busy) begin
            cpu_done = 1'b1;
            if (cpu_we) begin
                upd_en        = 1'b1;
                upd_line.st   = ST_M;
                upd_line.data = merge_word(cur.data, ofs, cpu_wdata);
            end
        end else if (fin && !snoop_busy) begin
            upd_en = 1'b1;
            case (bm_cmd)
                BC_WB: begin
                    upd_line.st = ST_I;
                end
                BC_INV: begin
                    cpu_done      = 1'b1;
                    upd_line.st   = ST_M;
                    upd_line.data = merge_word(cur.data, ofs, cpu_wdata);
                end
                BC_RDX: begin
                    cpu_done      = 1'b1;
                    upd_line.tag  = tag;
                    upd_line.st   = ST_M;
                    upd_line.data = merge_word(bm_rdata, ofs, cpu_wdata);
                end
                default: begin
                    cpu_done      = 1'b1;
                    cpu_rdata     = pick_word(bm_rdata, ofs);
                    upd_line.tag  = tag;
                    upd_line.st   = bm_shared ? ST_S : ST_E;
                    upd_line.data = bm_rdata;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
    import mesi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_done,
    output logic               cpu_stall,
    output logic               bm_req,
    input  logic               bm_gnt,
    output logic [2:0]         bm_cmd,
    output logic [LADDR_W-1:0] bm_laddr,
    output logic [LINE_W-1:0]  bm_wdata,
    input  logic [LINE_W-1:0]  bm_rdata,
    input  logic               bm_shared,
    input  logic               sn_valid,
    input  logic [2:0]         sn_cmd,
    input  logic [LADDR_W-1:0] sn_laddr,
    output logic               sn_hit,
    output logic               sn_supply,
    output logic               sn_wb,
    output logic [LINE_W-1:0]  sn_data
);

    line_t            cpu_line;
    line_t            snp_line;
    line_t            snp_upd;
    line_t            req_upd;
    line_t            wr_line;
    logic             snp_upd_en;
    logic             req_upd_en;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] snp_idx;
    bcmd_t            cmd_e;

    assign snp_idx = sn_laddr[IDX_W-1:0];

    mesi_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (idx_of(cpu_addr)),
        .rd_idx_b (snp_idx),
        .line_a   (cpu_line),
        .line_b   (snp_line),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_line  (wr_line)
    );

    mesi_snoop_unit u_snoop (
        .sn_valid  (sn_valid),
        .sn_cmd    (sn_cmd),
        .sn_laddr  (sn_laddr),
        .cur       (snp_line),
        .sn_hit    (sn_hit),
        .sn_supply (sn_supply),
        .sn_wb     (sn_wb),
        .sn_data   (sn_data),
        .upd_en    (snp_upd_en),
        .upd_line  (snp_upd)
    );

    mesi_req_ctrl u_ctrl (
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cur        (cpu_line),
        .snoop_busy (sn_valid),
        .bm_gnt     (bm_gnt),
        .bm_rdata   (bm_rdata),
        .bm_shared  (bm_shared),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .bm_req     (bm_req),
        .bm_cmd     (cmd_e),
        .bm_laddr   (bm_laddr),
        .bm_wdata   (bm_wdata),
        .upd_en     (req_upd_en),
        .upd_line   (req_upd)
    );

    assign bm_cmd    = cmd_e;
    assign cpu_stall = cpu_req && !cpu_done;

    // Snoop updates win the single array write port.
    assign wr_en   = snp_upd_en || req_upd_en;
    assign wr_idx  = snp_upd_en ? snp_idx : idx_of(cpu_addr);
    assign wr_line = snp_upd_en ? snp_upd : req_upd;

endmodule

// File: rtl/mesi_snoop_cache_chk.sv
module mesi_snoop_cache_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_req,
    input logic       cpu_done,
    input logic       cpu_stall,
    input logic       bm_req,
    input logic       bm_gnt,
    input logic [2:0] bm_cmd,
    input logic       sn_valid,
    input logic [2:0] sn_cmd,
    input logic       sn_hit,
    input logic       sn_supply,
    input logic       sn_wb
);

    assert_done_owned_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_req);

    assert_req_needs_cpu_R13: assert property (@(posedge clk) disable iff (rst)
        bm_req |-> cpu_req);

    assert_stall_waiting_R13: assert property (@(posedge clk) disable iff (rst)
        (bm_req && !bm_gnt) |-> cpu_stall);

    assert_snoop_first_R12: assert property (@(posedge clk) disable iff (rst)
        sn_valid |-> !cpu_done);

    assert_wb_with_supply_R8: assert property (@(posedge clk) disable iff (rst)
        sn_wb |-> (sn_supply && sn_hit));

    assert_inv_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (sn_valid && sn_cmd == 3'd3) |-> (!sn_supply && !sn_wb));

    assert_refill_after_wb_R11: assert property (@(posedge clk) disable iff (rst)
        (bm_req && bm_gnt && bm_cmd == 3'd4)
        |=> (!cpu_req || (bm_req && bm_cmd != 3'd4)));

endmodule

bind mesi_snoop_cache mesi_snoop_cache_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_done  (cpu_done),
    .cpu_stall (cpu_stall),
    .bm_req    (bm_req),
    .bm_gnt    (bm_gnt),
    .bm_cmd    (bm_cmd),
    .sn_valid  (sn_valid),
    .sn_cmd    (sn_cmd),
    .sn_hit    (sn_hit),
    .sn_supply (sn_supply),
    .sn_wb     (sn_wb)
);

// File: tb/test_mesi_snoop_cache.sv
module test_mesi_snoop_cache;
    import mesi_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cpu_req = 1'b0;
    logic               cpu_we = 1'b0;
    logic [ADDR_W-1:0]  cpu_addr = '0;
    logic [DATA_W-1:0]  cpu_wdata = '0;
    logic [DATA_W-1:0]  cpu_rdata;
    logic               cpu_done;
    logic               cpu_stall;
    logic               bm_req;
    logic               bm_gnt = 1'b0;
    logic [2:0]         bm_cmd;
    logic [LADDR_W-1:0] bm_laddr;
    logic [LINE_W-1:0]  bm_wdata;
    logic [LINE_W-1:0]  bm_rdata = '0;
    logic               bm_shared = 1'b0;
    logic               sn_valid = 1'b0;
    logic [2:0]         sn_cmd = '0;
    logic [LADDR_W-1:0] sn_laddr = '0;
    logic               sn_hit;
    logic               sn_supply;
    logic               sn_wb;
    logic [LINE_W-1:0]  sn_data;

    always #5 clk = ~clk;

    mesi_snoop_cache i_mesi_snoop_cache (.*);

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit                 is_bus;
        logic [2:0]         cmd;
        logic [LADDR_W-1:0] la;
        logic [LINE_W-1:0]  data;
        string              req;
    } exp_t;

    exp_t q[$];

    logic              shr_k  = 1'b0;
    logic              peer_k = 1'b0;
    logic [LINE_W-1:0] peer_line = '0;

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return DATA_W'(a) ^ 16'hA500;
    endfunction

    function automatic logic [LINE_W-1:0] mem_line(input logic [LADDR_W-1:0] la);
        logic [LINE_W-1:0] r;
        for (int w = 0; w < WORDS; w++)
            r[w*DATA_W +: DATA_W] = mem_word({la, OFS_W'(w)});
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bus responder: grants a pending request after two waiting cycles.
    initial begin
        int wait_cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            if (bm_gnt) begin
                bm_gnt = 1'b0;
            end else if (bm_req) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    check(cpu_stall == 1'b1, "R13", "stall while waiting", 64'(cpu_stall), 64'd1);
                    bm_rdata  = peer_k ? peer_line : mem_line(bm_laddr);
                    bm_shared = shr_k | peer_k;
                    bm_gnt    = 1'b1;
                    wait_cnt  = 0;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // Monitor: pops the scoreboard as bus transactions and completions occur.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && bm_req && bm_gnt) begin
                if (q.size() == 0 || !q[0].is_bus) begin
                    check(1'b0, (q.size() == 0) ? "R13" : q[0].req, "unexpected bus cmd",
                          64'(bm_cmd), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(bm_cmd == e.cmd, e.req, "bus cmd", 64'(bm_cmd), 64'(e.cmd));
                    check(bm_laddr == e.la, e.req, "bus line addr", 64'(bm_laddr), 64'(e.la));
                    if (e.cmd == 3'd4)
                        check(bm_wdata == e.data, e.req, "write-back line",
                              64'(bm_wdata), 64'(e.data));
                end
            end
            if (!rst && cpu_done) begin
                if (q.size() == 0 || q[0].is_bus) begin
                    check(1'b0, (q.size() == 0) ? "R2" : q[0].req, "unexpected completion",
                          64'(cpu_done), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (!cpu_we)
                        check(cpu_rdata == DATA_W'(e.data), e.req, "read data",
                              64'(cpu_rdata), 64'(e.data));
                    else
                        check(1'b1, e.req, "write done", 64'd1, 64'd1);
                end
            end
        end
    end

    task automatic exp_bus(input logic [2:0] cmd, input logic [LADDR_W-1:0] la,
                           input logic [LINE_W-1:0] d, input string req);
        exp_t e;
        e.is_bus = 1'b1; e.cmd = cmd; e.la = la; e.data = d; e.req = req;
        q.push_back(e);
    endtask

    task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] erd,
                          input string req);
        exp_t e;
        e.is_bus = 1'b0; e.cmd = 3'd0; e.la = '0; e.data = LINE_W'(erd); e.req = req;
        q.push_back(e);
        @(posedge clk);
        #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cpu_done) break;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [2:0] cmd, input logic [LADDR_W-1:0] la,
                         input bit eh, input bit es, input bit ew,
                         input logic [LINE_W-1:0] ed, input string req);
        @(posedge clk);
        #1;
        sn_valid = 1'b1; sn_cmd = cmd; sn_laddr = la;
        @(negedge clk);
        check(sn_hit == eh, req, "sn_hit", 64'(sn_hit), 64'(eh));
        check(sn_supply == es, req, "sn_supply", 64'(sn_supply), 64'(es));
        check(sn_wb == ew, req, "sn_wb", 64'(sn_wb), 64'(ew));
        if (es)
            check(sn_data == ed, req, "sn_data", 64'(sn_data), 64'(ed));
        @(posedge clk);
        #1;
        sn_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(cpu_stall == 1'b0, "R1", "stall after reset", 64'(cpu_stall), 64'd0);
        check(bm_req == 1'b0, "R1", "bm_req after reset", 64'(bm_req), 64'd0);
        snoop(3'd1, 9'h008, 0, 0, 0, '0, "R1");

        // R3: read miss, no holder -> E
        exp_bus(3'd1, 9'h008, '0, "R3");
        cpu_op(0, 10'h010, '0, 16'hA510, "R3");
        // R5: write hit E, no bus
        cpu_op(1, 10'h011, 16'h1111, '0, "R5");
        // R2: read hit
        cpu_op(0, 10'h011, '0, 16'h1111, "R2");
        // R6: snooped read of M line
        snoop(3'd1, 9'h008, 1, 1, 1, {16'h1111, 16'hA510}, "R6");
        snoop(3'd1, 9'h008, 1, 1, 0, {16'h1111, 16'hA510}, "R6");
        // R7: write hit S -> invalidate
        exp_bus(3'd3, 9'h008, '0, "R7");
        cpu_op(1, 10'h010, 16'h2222, '0, "R7");
        // R8: snooped RDX of M line
        snoop(3'd2, 9'h008, 1, 1, 1, {16'h1111, 16'h2222}, "R8");
        // R4: read miss with holder -> S, data from bus
        peer_k = 1'b1; peer_line = {16'h3333, 16'h4444};
        exp_bus(3'd1, 9'h008, '0, "R4");
        cpu_op(0, 10'h010, '0, 16'h4444, "R4");
        peer_k = 1'b0;
        exp_bus(3'd3, 9'h008, '0, "R4");
        cpu_op(1, 10'h011, 16'h5151, '0, "R4");
        snoop(3'd2, 9'h008, 1, 1, 1, {16'h5151, 16'h4444}, "R8");
        // R9: snooped invalidate of S line
        exp_bus(3'd1, 9'h008, '0, "R3");
        cpu_op(0, 10'h011, '0, 16'hA511, "R3");
        snoop(3'd1, 9'h008, 1, 1, 0, {16'hA511, 16'hA510}, "R6");
        snoop(3'd3, 9'h008, 0, 0, 0, '0, "R9");
        exp_bus(3'd1, 9'h008, '0, "R9");
        cpu_op(0, 10'h010, '0, 16'hA510, "R9");
        // R14: other tag, same index
        snoop(3'd1, 9'h018, 0, 0, 0, '0, "R14");
        snoop(3'd2, 9'h008, 1, 1, 0, {16'hA511, 16'hA510}, "R14");
        // R10: write miss -> RDX, M
        exp_bus(3'd2, 9'h018, '0, "R10");
        cpu_op(1, 10'h030, 16'h5555, '0, "R10");
        // R11: dirty victim written back first
        exp_bus(3'd4, 9'h018, {16'hA531, 16'h5555}, "R11");
        exp_bus(3'd1, 9'h028, '0, "R11");
        cpu_op(0, 10'h050, '0, 16'hA550, "R11");
        // R11: clean victim dropped silently
        exp_bus(3'd1, 9'h038, '0, "R11");
        cpu_op(0, 10'h070, '0, 16'hA570, "R11");

        // R12: snoop in the same cycle as a hit holds the completion
        begin
            exp_t e;
            e.is_bus = 1'b0; e.cmd = 3'd0; e.la = '0; e.data = LINE_W'(16'hA571); e.req = "R12";
            q.push_back(e);
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h071;
        sn_valid = 1'b1; sn_cmd = 3'd1; sn_laddr = 9'h1FF;
        @(negedge clk);
        check(cpu_done == 1'b0, "R12", "done during snoop", 64'(cpu_done), 64'd0);
        check(cpu_stall == 1'b1, "R12", "stall during snoop", 64'(cpu_stall), 64'd1);
        @(posedge clk);
        #1;
        sn_valid = 1'b0;
        @(negedge clk);
        check(cpu_done == 1'b1, "R12", "done after snoop", 64'(cpu_done), 64'd1);
        @(posedge clk);
        #1;
        cpu_req = 1'b0;

        // R5: E then M write hits stay local
        cpu_op(1, 10'h070, 16'h7777, '0, "R5");
        cpu_op(1, 10'h071, 16'h7878, '0, "R5");
        cpu_op(0, 10'h070, '0, 16'h7777, "R2");
        snoop(3'd1, 9'h038, 1, 1, 1, {16'h7878, 16'h7777}, "R5");

        repeat (3) @(posedge clk);
        check(q.size() == 0, "R13", "scoreboard drained", 64'(q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R13 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule